// File: doc/BRIEF.md
# Interval Timer Counting Channel

This block is a single 16-bit down-counting channel of a programmable interval timer. It advances only on cycles where the count-enable `tick` is high. The channel takes an operating mode, a reload value with a one-cycle load strobe, and a gate level. It drives an output level, the live count, and a one-cycle interrupt request that marks each low-to-high change of the output level.

Three operating behaviours are supported, selected by `mode`:

- **One-shot terminal count** (`00`, and also `01`): the output goes high when the count reaches zero. Counting then continues from the wrap.
- **Rate generator** (`10`): the output drops low for the single tick on which the count equals one. The counter then reloads.
- **Square wave** (`11`): the count steps by two from an even reload. The output toggles at each expiry.

Gate edges restart, pause or stop the channel according to the mode. Events in the same clock have a fixed priority: a load is handled first, then a gate edge, then a tick.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset, `count` is 0, `out_lvl` is 1, `irq` is 0 and the channel is inactive, so ticks leave `count` at 0.
- R2: In mode 00/01, a load copies `reload` into `count` and arms the channel. If `gate` is high during the load, `out_lvl` goes low in the same update.
- R3: In mode 00/01, each tick decrements `count`. When `count` reaches 0, `out_lvl` goes high. The next tick wraps `count` to 0xFFFF and leaves `out_lvl` high.
- R4: In mode 10, `out_lvl` is high except after the tick that brings `count` to 1. The following tick reloads `count` and returns `out_lvl` high.
- R5: In mode 11, the low bit of the reload is cleared and each tick subtracts 2. A tick at a count of 2 or less reloads `count` and toggles `out_lvl`.
- R6: In modes 10/11, a load with `gate` high and the channel idle starts counting from the reload with `out_lvl` high. A reload of 1 in these modes is illegal: the channel goes idle with `out_lvl` high.
- R7: A rising `gate` reloads `count` from the stored reload in every mode. In modes 10/11 it also starts counting with `out_lvl` high. In mode 00/01 it drives `out_lvl` low if the channel is armed.
- R8: A falling `gate` in modes 10/11 stops counting and forces `out_lvl` high in the next update. In mode 00/01 it only pauses counting.
- R9: `count` changes on a tick only while `gate` is high and the channel is active.
- R10: `irq` is high for exactly the first cycle in which `out_lvl` is 1 after having been 0.
- R11: A reload of 0 acts as 65536. In mode 10, a first tick from a count of 0 gives 0xFFFF.
- R12: When a load and a tick fall in the same cycle, the load wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one pulse per count step |
| mode | input | 2 | 00/01 terminal count, 10 rate generator, 11 square wave |
| reload | input | 16 | Reload value (0 means 65536) |
| ld | input | 1 | Load strobe for `reload` |
| gate | input | 1 | Gate level |
| out_lvl | output | 1 | Channel output level |
| count | output | 16 | Live counter value |
| irq | output | 1 | One-cycle pulse on a rising `out_lvl` |

## Verification
Two pairs of functions can collide in one cycle.

- **Load and tick:** a load arriving together with a count tick is provoked in terminal-count mode. It is judged by the count landing exactly on the new reload, not one below it.
- **Gate edge and tick or load:** the bench applies a gate edge with no tick and then ticks with the gate low. The expected count and output level are checked after each update.

Interrupt pulses are checked on the very cycle the output rises in the rate-generator and square-wave runs.

// File: rtl/interval_timer_chan.sv
module interval_timer_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [W-1:0] reload,
  input  logic         ld,
  input  logic         gate,
  output logic         out_lvl,
  output logic [W-1:0] count,
  output logic         irq
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] TWO  = W'(2);
  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [W-1:0] EVN1 = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] rld_q;
  logic         active, gate_q, out_q;

  wire          periodic = mode[1];
  wire          square   = (mode == 2'b11);
  wire          rise     = gate & ~gate_q;
  wire          fall     = ~gate & gate_q;
  wire [W-1:0]  ld_val   = square ? {reload[W-1:1], 1'b0} : reload;
  wire          bad_ld   = periodic && (reload == ONE);

  assign irq = out_lvl & ~out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      rld_q   <= '0;
      active  <= 1'b0;
      gate_q  <= 1'b0;
      out_lvl <= 1'b1;
      out_q   <= 1'b1;
    end else begin
      gate_q <= gate;
      out_q  <= out_lvl;
      if (ld) begin
        if (!periodic) begin
          rld_q  <= ld_val;
          count  <= ld_val;
          active <= 1'b1;
          if (gate) out_lvl <= 1'b0;
        end else if (bad_ld) begin
          active  <= 1'b0;
          out_lvl <= 1'b1;
        end else begin
          rld_q <= ld_val;
          if (gate && (!active || rise)) begin
            count   <= ld_val;
            active  <= 1'b1;
            out_lvl <= 1'b1;
          end else if (fall) begin
            active  <= 1'b0;
            out_lvl <= 1'b1;
          end
        end
      end else if (rise) begin
        count <= rld_q;
        if (periodic) begin
          active  <= 1'b1;
          out_lvl <= 1'b1;
        end else if (active) begin
          out_lvl <= 1'b0;
        end
      end else if (fall) begin
        if (periodic) begin
          active  <= 1'b0;
          out_lvl <= 1'b1;
        end
      end else if (tick && gate && active) begin
        if (!periodic) begin
          if (count == '0) begin
            count <= ALL1;
          end else begin
            count <= count - ONE;
            if (count == ONE) out_lvl <= 1'b1;
          end
        end else if (!square) begin
          if (count == '0) begin
            count   <= ALL1;
            out_lvl <= 1'b1;
          end else if (count == ONE) begin
            count   <= rld_q;
            out_lvl <= 1'b1;
          end else if (count == TWO) begin
            count   <= ONE;
            out_lvl <= 1'b0;
          end else begin
            count <= count - ONE;
          end
        end else begin
          if (count == '0) begin
            count <= EVN1;
          end else if (count <= TWO) begin
            count   <= rld_q;
            out_lvl <= ~out_lvl;
          end else begin
            count <= count - TWO;
          end
        end
      end
    end
  end
endmodule

module interval_timer_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [1:0]   mode,
  input logic [W-1:0] reload,
  input logic         ld,
  input logic         gate,
  input logic         out_lvl,
  input logic [W-1:0] count,
  input logic         irq
);
  // R10
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (out_lvl && !$past(out_lvl)));

  // R9
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld && $stable(gate)) |=> $stable(count));

  // R6
  bad_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && mode[1] && reload == W'(1)) |=> out_lvl);

  // R8
  gate_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !gate && $past(gate)) |=> out_lvl);

  // R4
  rate_low_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !out_lvl && tick && gate && $stable(gate) && !ld) |=> out_lvl);
endmodule

bind interval_timer_chan interval_timer_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .reload(reload),
  .ld(ld), .gate(gate), .out_lvl(out_lvl), .count(count), .irq(irq));

// File: tb/test_interval_timer_chan.sv
module test_interval_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] reload = '0;
  logic        ld = 1'b0;
  logic        gate = 1'b0;
  logic        out_lvl, irq;
  logic [15:0] count;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  interval_timer_chan i_interval_timer_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .reload(reload),
    .ld(ld), .gate(gate), .out_lvl(out_lvl), .count(count), .irq(irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic state(input string tag, input logic [15:0] c, input logic o, input logic q);
    chk({tag, " count"}, count, c);
    chk({tag, " out"}, {15'd0, out_lvl}, {15'd0, o});
    chk({tag, " irq"}, {15'd0, irq}, {15'd0, q});
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] v);
    reload = v; ld = 1'b1; cyc(); ld = 1'b0;
  endtask

  task automatic t_reset();
    state("R1 reset", 16'd0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) do_tick();
    state("R1 ticks gate low", 16'd0, 1'b1, 1'b0);
    gate = 1'b1; cyc();
    do_tick();
    state("R9 inactive tick", 16'd0, 1'b1, 1'b0);
  endtask

  task automatic t_oneshot();
    mode = 2'b00;
    do_load(16'd5);
    state("R2 load", 16'd5, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) do_tick();
    state("R3 count 1", 16'd1, 1'b0, 1'b0);
    do_tick();
    state("R3 zero", 16'd0, 1'b1, 1'b1);
    cyc();
    chk("R10 irq single", {15'd0, irq}, 16'd0);
    do_tick();
    state("R3 wrap", 16'hFFFF, 1'b1, 1'b0);
    gate = 1'b0; cyc();
    do_tick();
    state("R8 mode0 pause", 16'hFFFF, 1'b1, 1'b0);
    gate = 1'b1; cyc();
    state("R7 mode0 rise", 16'd5, 1'b0, 1'b0);
    reload = 16'd7; ld = 1'b1; tick = 1'b1; cyc(); ld = 1'b0; tick = 1'b0;
    state("R12 load beats tick", 16'd7, 1'b0, 1'b0);
  endtask

  task automatic t_rate();
    gate = 1'b0; cyc();
    mode = 2'b10;
    do_load(16'd3);
    chk("R9 load gate low keeps count", count, 16'd7);
    gate = 1'b1; cyc();
    state("R7 rate rise", 16'd3, 1'b1, 1'b1);
    do_tick();
    state("R4 count 2", 16'd2, 1'b1, 1'b0);
    do_tick();
    state("R4 low at 1", 16'd1, 1'b0, 1'b0);
    do_tick();
    state("R4 reload", 16'd3, 1'b1, 1'b1);
    do_tick(); do_tick();
    state("R4 low again", 16'd1, 1'b0, 1'b0);
    gate = 1'b0; cyc();
    state("R8 rate fall", 16'd1, 1'b1, 1'b1);
    do_tick();
    state("R8 stopped", 16'd1, 1'b1, 1'b0);
    gate = 1'b1; cyc();
    state("R7 rate restart", 16'd3, 1'b1, 1'b0);
    do_load(16'd1);
    do_tick();
    state("R6 illegal idle", 16'd3, 1'b1, 1'b0);
    do_load(16'd6);
    state("R6 idle start", 16'd6, 1'b1, 1'b0);
    do_tick();
    chk("R6 counting", count, 16'd5);
    do_load(16'd1);
    do_load(16'd0);
    chk("R11 zero load", count, 16'd0);
    do_tick();
    state("R11 wrap", 16'hFFFF, 1'b1, 1'b0);
    do_tick();
    chk("R11 continue", count, 16'hFFFE);
  endtask

  task automatic t_square();
    gate = 1'b0; cyc();
    mode = 2'b11;
    do_load(16'd7);
    gate = 1'b1; cyc();
    state("R5 even reload", 16'd6, 1'b1, 1'b0);
    do_tick();
    chk("R5 step 2", count, 16'd4);
    do_tick();
    chk("R5 step 2b", count, 16'd2);
    do_tick();
    state("R5 toggle low", 16'd6, 1'b0, 1'b0);
    do_tick(); do_tick();
    chk("R5 half 2", count, 16'd2);
    do_tick();
    state("R5 toggle high", 16'd6, 1'b1, 1'b1);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_oneshot();
    t_rate();
    t_square();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule